// File: doc/BRIEF.md
# Banked Phase-Accumulator Oscillator

This block is a numerically controlled oscillator. A 28-bit accumulator advances by a frequency step on every clock. The top twelve bits of the accumulator, plus a 12-bit phase offset, form a phase word. A waveform lookup downstream turns that word into a sample. The step comes from a bank of sixteen frequency entries and the offset from a bank of sixteen phase entries. A sequencer picks one entry of each bank on every cycle, so a pulse program can jump in frequency or phase with no added latency.

A host fills both banks through a simple write port before the sequencer starts. The port takes a bank bit, an entry index and a data word, and it is locked while the sequencer is running. Two level controls shape the output:
- A phase-reset input holds the accumulator at zero. While it is held, the phase word equals the selected offset, which gives a steady level that can be used to line up scans.
- An output-enable input gates the phase word to zero.

A frequency entry of zero together with a chosen offset gives a constant output.

Top module: `banked_nco`

## Requirements
- R1: While reset is asserted and after it is released, every frequency and phase entry reads zero and the accumulator is zero. With outEnable high and phaseReset low, phaseOut is 0 until a nonzero entry is written and selected.
- R2: On every rising clock edge with phaseReset low, the accumulator becomes (accumulator + frequency entry[freqSel]) modulo 2^28, and it wraps past 2^28 - 1.
- R3: When outEnable is high and phaseReset is low, phaseOut equals (accumulator bits 27..16 + phase entry[phaseSel]) modulo 4096.
- R4: A change on freqSel sets the step used at the very next clock edge, with no extra cycle of delay.
- R5: A change on phaseSel changes phaseOut in the same cycle, combinationally.
- R6: While phaseReset is high, phaseOut equals phase entry[phaseSel] (when enabled) and the accumulator is cleared at each edge. After release, accumulation restarts from zero.
- R7: When outEnable is low, phaseOut is 0. The accumulator keeps advancing underneath, so the phase stays continuous once the output is enabled again.
- R8: A write with hostWrEn high and seqActive low lands at the clock edge. hostBank=0 stores hostData[27:0] into frequency entry hostIdx. hostBank=1 stores hostData[11:0] into phase entry hostIdx.
- R9: A write presented while seqActive is high changes no entry.
- R10: With a selected frequency entry of zero and phaseReset low, phaseOut stays constant from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostBank | input | 1 | 0 selects the frequency bank, 1 selects the phase bank |
| hostIdx | input | 4 | Entry index of the write |
| hostData | input | 28 | Write data; the phase bank uses bits 11..0 |
| seqActive | input | 1 | Sequencer running; blocks host writes |
| freqSel | input | 4 | Frequency entry in use |
| phaseSel | input | 4 | Phase entry in use |
| phaseReset | input | 1 | Holds the accumulator at zero |
| outEnable | input | 1 | Gates phaseOut; low forces zero |
| phaseOut | output | 12 | Phase word to the waveform lookup |

## Verification
The hardest situation to reach is a write that arrives while the sequencer is active. Its only visible effect is that nothing happens, so the bench has to show that absence through the output. The directed stimulus locks the port and tries to overwrite the zero frequency entry with a large step. It then selects that entry and shows that phaseOut stays flat. The random stimulus toggles seqActive together with writes, selects, phase reset and gating, and compares every cycle against a bench model of the banks and the accumulator. Wrap cases use a step of all ones and an offset of 0xFFF, so both modulo sums are exercised.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int FREQ_W  = 28;
  localparam int PHASE_W = 12;
  localparam int SEL_W   = 4;
  localparam int ENTRIES = 1 << SEL_W;

  // Strobes and words handed from control to datapath each cycle
  typedef struct packed {
    logic               accClear;
    logic               gateOn;
    logic [FREQ_W-1:0]  step;
    logic [PHASE_W-1:0] offset;
  } nco_ctl_t;
endpackage

// File: rtl/nco_bank.sv
module nco_bank #(
  parameter int WIDTH = 28,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [SEL_W-1:0] rdIdx,
  output logic [WIDTH-1:0] rdData
);
  localparam int DEPTH = 1 << SEL_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrIdx] <= wrData;
    end
  end

  assign rdData = mem[rdIdx];

  for (genvar g = 0; g < DEPTH; g++) begin : gChk
    // R8: an accepted write lands in the addressed entry
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && wrIdx == SEL_W'(g)) |=> mem[g] == $past(wrData));
    // R9: without an accepted write an entry keeps its value
    assert_entry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wrEn && wrIdx == SEL_W'(g)) |=> $stable(mem[g]));
  end
endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic              hostBank,
  input  logic [SEL_W-1:0]  hostIdx,
  input  logic [FREQ_W-1:0] hostData,
  input  logic              seqActive,
  input  logic [SEL_W-1:0]  freqSel,
  input  logic [SEL_W-1:0]  phaseSel,
  input  logic              phaseReset,
  input  logic              outEnable,
  output nco_ctl_t          ctl
);
  logic               wrAccept;
  logic               wrFreq;
  logic               wrPhase;
  logic [FREQ_W-1:0]  freqWord;
  logic [PHASE_W-1:0] phaseWord;

  assign wrAccept = hostWrEn && !seqActive;
  assign wrFreq   = wrAccept && !hostBank;
  assign wrPhase  = wrAccept && hostBank;

  nco_bank #(.WIDTH(FREQ_W), .SEL_W(SEL_W)) i_freqBank (
    .clk(clk), .rst_n(rst_n), .wrEn(wrFreq), .wrIdx(hostIdx),
    .wrData(hostData), .rdIdx(freqSel), .rdData(freqWord));

  nco_bank #(.WIDTH(PHASE_W), .SEL_W(SEL_W)) i_phaseBank (
    .clk(clk), .rst_n(rst_n), .wrEn(wrPhase), .wrIdx(hostIdx),
    .wrData(hostData[PHASE_W-1:0]), .rdIdx(phaseSel), .rdData(phaseWord));

  always_comb begin
    ctl.accClear = phaseReset;
    ctl.gateOn   = outEnable;
    ctl.step     = freqWord;
    ctl.offset   = phaseWord;
  end

  // R9: a locked port never raises a bank write strobe
  assert_locked_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seqActive |-> !(wrFreq || wrPhase));
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  nco_ctl_t           ctl,
  output logic [PHASE_W-1:0] phaseOut
);
  logic [FREQ_W-1:0]  acc;
  logic [FREQ_W-1:0]  accView;
  logic [PHASE_W-1:0] phaseSum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc <= '0;
    else if (ctl.accClear) acc <= '0;
    else                   acc <= acc + ctl.step;
  end

  assign accView  = ctl.accClear ? '0 : acc;
  assign phaseSum = accView[FREQ_W-1 -: PHASE_W] + ctl.offset;
  assign phaseOut = ctl.gateOn ? phaseSum : '0;

  // R6: a held phase reset leaves the accumulator at zero
  assert_acc_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.accClear |=> acc == '0);
  // R2: accumulation wraps modulo 2^FREQ_W
  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.accClear |=> acc == FREQ_W'($past(acc) + $past(ctl.step)));
  // R10: a zero step freezes the accumulator
  assert_zero_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.accClear && ctl.step == '0) |=> $stable(acc));
endmodule

// File: rtl/banked_nco.sv
module banked_nco
  import nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hostWrEn,
  input  logic               hostBank,
  input  logic [SEL_W-1:0]   hostIdx,
  input  logic [FREQ_W-1:0]  hostData,
  input  logic               seqActive,
  input  logic [SEL_W-1:0]   freqSel,
  input  logic [SEL_W-1:0]   phaseSel,
  input  logic               phaseReset,
  input  logic               outEnable,
  output logic [PHASE_W-1:0] phaseOut
);
  nco_ctl_t ctl;

  nco_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostBank(hostBank),
    .hostIdx(hostIdx), .hostData(hostData), .seqActive(seqActive),
    .freqSel(freqSel), .phaseSel(phaseSel), .phaseReset(phaseReset),
    .outEnable(outEnable), .ctl(ctl));

  nco_datapath i_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .phaseOut(phaseOut));

  // R7: gating at the port forces a zero phase word
  assert_gate_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !outEnable |-> phaseOut == '0);
endmodule

// File: tb/test_banked_nco.sv
module test_banked_nco;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostWrEn = 1'b0, hostBank = 1'b0;
  logic [3:0]  hostIdx = '0;
  logic [27:0] hostData = '0;
  logic        seqActive = 1'b0;
  logic [3:0]  freqSel = '0, phaseSel = '0;
  logic        phaseReset = 1'b0, outEnable = 1'b1;
  logic [11:0] phaseOut;

  int total = 0, bad = 0;
  logic [27:0] fb [16];
  logic [11:0] pb [16];
  logic [27:0] mAcc;
  bit done = 0;

  always #10 clk = ~clk;

  banked_nco i_banked_nco (.*);

  function automatic logic [11:0] expPhase();
    logic [27:0] v;
    v = phaseReset ? 28'd0 : mAcc;
    return outEnable ? 12'(v[27:16] + pb[phaseSel]) : 12'd0;
  endfunction

  task automatic check(string tag);
    logic [11:0] e;
    #2;
    e = expPhase();
    total++;
    if (phaseOut !== e) begin
      bad++;
      $display("FAIL %s phaseOut=%h expected=%h", tag, phaseOut, e);
    end
  endtask

  task automatic cycle(string tag);
    check(tag);
    @(posedge clk);
    mAcc = phaseReset ? 28'd0 : 28'(mAcc + fb[freqSel]);
    if (hostWrEn && !seqActive) begin
      if (hostBank) pb[hostIdx] = hostData[11:0];
      else          fb[hostIdx] = hostData;
    end
    @(negedge clk);
  endtask

  task automatic hostWrite(bit bank, int idx, logic [27:0] d, string tag);
    hostWrEn = 1; hostBank = bank; hostIdx = 4'(idx); hostData = d;
    cycle(tag);
    hostWrEn = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) begin fb[i] = '0; pb[i] = '0; end
    mAcc = '0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    // R1: nothing written yet, output stays at zero
    freqSel = 4'd7; phaseSel = 4'd9;
    repeat (3) cycle("R1");
    freqSel = 0; phaseSel = 0;
    // R8: load both banks
    hostWrite(0, 1, 28'h0123456, "R8");
    hostWrite(0, 2, 28'h8000000, "R8");
    hostWrite(0, 4, 28'hFFFFFFF, "R8");
    hostWrite(1, 3, 28'hABCD400, "R8");
    hostWrite(1, 5, 28'h0000FFF, "R8");
    seqActive = 1;
    // R2: steady accumulation
    freqSel = 1; phaseSel = 0;
    repeat (20) cycle("R2");
    // R4 / R5: per-cycle select switching
    for (int i = 0; i < 10; i++) begin
      freqSel = (i % 2) ? 4'd2 : 4'd1; phaseSel = (i % 2) ? 4'd3 : 4'd0;
      cycle("R4");
      phaseSel = (i % 3 == 0) ? 4'd5 : 4'd3;
      cycle("R5");
    end
    // R6: held phase reset, then release
    phaseSel = 3; phaseReset = 1;
    repeat (5) cycle("R6");
    phaseReset = 0;
    repeat (5) cycle("R6");
    // R7: gating and continuity after re-enable
    outEnable = 0;
    repeat (5) cycle("R7");
    outEnable = 1;
    repeat (3) cycle("R7");
    // R10: zero step holds the output constant
    freqSel = 0; phaseSel = 5;
    repeat (6) cycle("R10");
    // R9: a write while the sequencer runs is dropped
    hostWrite(0, 0, 28'hFFFFFFF, "R9");
    hostWrite(1, 5, 28'h0000123, "R9");
    repeat (6) cycle("R9");
    // R2 / R3: wrap of the accumulator and the offset sum
    freqSel = 4; phaseSel = 5;
    repeat (8) cycle("R2");
    freqSel = 2;
    repeat (8) cycle("R3");
    // R3: random mix
    for (int i = 0; i < 3000; i++) begin
      hostWrEn   = ($urandom % 8) == 0;
      hostBank   = 1'($urandom);
      hostIdx    = 4'($urandom);
      hostData   = 28'($urandom);
      seqActive  = ($urandom % 3) != 0;
      freqSel    = 4'($urandom);
      phaseSel   = 4'($urandom);
      phaseReset = ($urandom % 16) == 0;
      outEnable  = ($urandom % 8) != 0;
      cycle("R3");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule